// File: doc/BRIEF.md
# Processor-Side Bidirectional I/O Port with Floating-Bit Decay

This block is an eight-bit general-purpose port that sits on a processor's internal bus at two addresses. Address 0 holds a direction mask and address 1 holds the port value. A direction bit set to 1 makes that port bit an output, and a direction bit cleared to 0 makes it an input. The six low bits reach package pins through separate output, output-enable and input signals. Bit 4 is wired as a sense input and never drives its pin. The two high bits have register state but no pin.

A high bit that is set as an input has no pin, so nothing defines its level. The block gives it the behaviour of a node that is left to charge up. Suppose such a bit is driven low and then released to input. It reads back 0 for a programmable number of clock cycles, and after that it reads 1. A bit that is released while it is high reads 1 at once. If the bit is turned back into an output, any decay window still running for it is abandoned.

Bus reads are registered. Read data appears one cycle after the read strobe and holds until the next read. A read and a write issued in the same cycle return the register contents from before the write.

Top module: `proc_io_port`

## Requirements
- R1: After reset the direction register is 0x00 and the port register is 0x00. Both `pin_oe` and `pin_out` are all zero, and the two pinless bits read as 1.
- R2: A write with `bus_addr`=0 stores all eight bits of `bus_wdata` in the direction register. A later read at address 0 returns them.
- R3: A write with `bus_addr`=1 stores all eight bits in the port register. When address 1 is read, each bit whose direction bit is 1 (other than bit 4) returns the port register bit.
- R4: `pin_out[i]` equals port register bit i, and `pin_oe[i]` equals direction bit i, for each pinned bit i in 0..5 except bit 4.
- R5: When address 1 is read, a pinned bit whose direction bit is 0 returns `pin_in` at that bit, sampled at the read edge.
- R6: Bit 4 never drives its pin (`pin_oe[4]` is always 0). When address 1 is read, bit 4 always returns `pin_in[4]`, even when its direction bit is 1.
- R7: Bits 6 and 7 have no pin. When they are outputs, a read of address 1 returns their port register value.
- R8: A pinless bit is released at write edge W when a direction write clears a direction bit that was 1 while the port bit is 0. Reads sampled at edges W+1 through W+DECAY_CYCLES return 0 for that bit. Reads at W+DECAY_CYCLES+1 and later return 1.
- R9: A pinless bit that is released while its port bit is 1 reads 1 from the first read after the release.
- R10: A direction write that sets a pinless bit to 1 abandons any decay window running for that bit. If the bit is then released while high, it reads 1 at once.
- R11: `rd_data` is loaded at the edge where `rd_en` is high and holds otherwise. If a write occurs at the same edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 direction, 1 port value |
| bus_wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 6 | Sampled levels of the pinned bits |
| pin_out | output | 6 | Levels driven onto the pinned bits |
| pin_oe | output | 6 | Output enables of the pinned bits |

## Verification
A write is visible on `pin_out` and `pin_oe` one edge after its strobe, and read data is visible one edge after `rd_en`. The bench therefore drives at the falling edge and samples at the next falling edge, after the rising edge that consumes the strobe. The decay window is counted from the edge where the releasing direction write is taken. The bench runs with a short window and places its reads at the last edge that must still return 0 and at the first edge that must return 1, counting idle cycles between the release and those reads. The same-cycle read/write case checks `rd_data` before the written value is read back.

// File: rtl/proc_io_pkg.sv
package proc_io_pkg;
   // register select decoded from the one-bit bus address
   typedef enum logic {
      SEL_DIR  = 1'b0,
      SEL_PORT = 1'b1
   } io_sel_e;
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
   import proc_io_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  io_sel_e          sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] port_q,
   output logic             dir_wr
);
   logic port_wr;

   assign dir_wr  = wr_en && (sel == SEL_DIR);
   assign port_wr = wr_en && (sel == SEL_PORT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else begin
         if (dir_wr)  dir_q  <= wdata;
         if (port_wr) port_q <= wdata;
      end
   end

   // R2
   dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> dir_q == $past(wdata));

   // R3
   port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |=> port_q == $past(wdata));
endmodule

// File: rtl/io_decay_cell.sv
module io_decay_cell #(
   parameter int DECAY_CYCLES = 344750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic cancel_i,
   output logic float_o
);
   localparam int CW = $clog2(DECAY_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(DECAY_CYCLES);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (cancel_i) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= LOAD_VAL;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   // a running window holds the last driven low level
   assign float_o = (remain_q == '0);

   // R8
   decay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !cancel_i |=> !float_o);

   // R8
   decay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(float_o) |-> $past(load_i));

   // R10
   decay_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_i |=> float_o);
endmodule

// File: rtl/proc_io_port.sv
module proc_io_port
   import proc_io_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter int PIN_BITS     = 6,
   parameter int SENSE_BIT    = 4,
   parameter int DECAY_CYCLES = 344750
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_addr,
   input  logic [WIDTH-1:0]    bus_wdata,
   input  logic                wr_en,
   input  logic                rd_en,
   output logic [WIDTH-1:0]    rd_data,
   input  logic [PIN_BITS-1:0] pin_in,
   output logic [PIN_BITS-1:0] pin_out,
   output logic [PIN_BITS-1:0] pin_oe
);
   initial begin
      assert (PIN_BITS >= 1 && PIN_BITS <= WIDTH)
         else $error("PIN_BITS must lie in 1..WIDTH");
      assert (SENSE_BIT >= 0 && SENSE_BIT < PIN_BITS)
         else $error("SENSE_BIT must be a pinned bit");
      assert (DECAY_CYCLES >= 1)
         else $error("DECAY_CYCLES must be at least 1");
   end

   io_sel_e          sel;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] port_q;
   logic             dir_wr;
   logic [WIDTH-1:0] port_view;

   assign sel = io_sel_e'(bus_addr);

   io_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .sel    (sel),
      .wdata  (bus_wdata),
      .dir_q  (dir_q),
      .port_q (port_q),
      .dir_wr (dir_wr)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < PIN_BITS) begin : g_pinned
         if (i == SENSE_BIT) begin : g_sense
            assign pin_out[i]   = port_q[i];
            assign pin_oe[i]    = 1'b0;
            assign port_view[i] = pin_in[i];
         end else begin : g_gpio
            assign pin_out[i]   = port_q[i];
            assign pin_oe[i]    = dir_q[i];
            assign port_view[i] = dir_q[i] ? port_q[i] : pin_in[i];
         end
      end else begin : g_floating
         logic float_lvl;
         logic rel_low;
         logic reclaim;

         // released from a driven-low state at this edge
         assign rel_low = dir_wr && dir_q[i] && !bus_wdata[i] && !port_q[i];
         assign reclaim = dir_wr && bus_wdata[i];

         io_decay_cell #(.DECAY_CYCLES(DECAY_CYCLES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (rel_low),
            .cancel_i (reclaim),
            .float_o  (float_lvl)
         );

         assign port_view[i] = dir_q[i] ? port_q[i] : float_lvl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= (sel == SEL_DIR) ? dir_q : port_view;
      end
   end

   // R11
   rd_old_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (sel == SEL_DIR) |=> rd_data == $past(dir_q));

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R6
   sense_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (sel == SEL_PORT) |=> rd_data[SENSE_BIT] == $past(pin_in[SENSE_BIT]));

   // R4
   oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> pin_oe == ($past(bus_wdata[PIN_BITS-1:0]) & ~(PIN_BITS'(1) << SENSE_BIT)));
endmodule

// File: tb/tb_proc_io_port.sv
module tb_proc_io_port;
   localparam int D = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [5:0] pin_in = '0;
   logic [5:0] pin_out;
   logic [5:0] pin_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   proc_io_port #(.DECAY_CYCLES(D)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // {op(2): 0 write 1 read, addr(1), wdata(8), pin(6), expected(8)}
   localparam int NV = 11;
   localparam logic [24:0] VEC [0:NV-1] = '{
      {2'd0, 1'b0, 8'hFF, 6'h00, 8'h00},
      {2'd0, 1'b1, 8'hA5, 6'h00, 8'h00},
      {2'd1, 1'b1, 8'h00, 6'h10, 8'hB5},
      {2'd1, 1'b0, 8'h00, 6'h00, 8'hFF},
      {2'd0, 1'b0, 8'hC0, 6'h00, 8'h00},
      {2'd1, 1'b1, 8'h00, 6'h2B, 8'hAB},
      {2'd1, 1'b1, 8'h00, 6'h14, 8'h94},
      {2'd0, 1'b1, 8'hE5, 6'h00, 8'h00},
      {2'd0, 1'b0, 8'h0F, 6'h00, 8'h00},
      {2'd1, 1'b1, 8'h00, 6'h00, 8'hC5},
      {2'd1, 1'b0, 8'h00, 6'h00, 8'h0F}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] v);
      bus_addr = a; bus_wdata = v; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] v);
      bus_addr = a; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pin_oe", {2'b00, pin_oe}, 8'h00);
      check("R1 pin_out", {2'b00, pin_out}, 8'h00);
      bus_read(1'b0, r); check("R1 dir", r, 8'h00);
      pin_in = 6'h15;
      bus_read(1'b1, r); check("R1 port floats high", r, 8'hD5);

      // R2 R3 R5 R6 R7 vector walk
      for (int k = 0; k < NV; k++) begin
         pin_in = VEC[k][13:8];
         if (VEC[k][24:23] == 2'd0) begin
            bus_write(VEC[k][22], VEC[k][21:14]);
         end else begin
            bus_read(VEC[k][22], r);
            check($sformatf("R2/R3/R5/R6/R7 vec%0d", k), r, VEC[k][7:0]);
         end
      end

      // R4 R6 pin drive
      bus_write(1'b0, 8'hFF);
      bus_write(1'b1, 8'h3F);
      check("R4 pin_out", {2'b00, pin_out}, 8'h3F);
      check("R6 pin_oe sense bit off", {2'b00, pin_oe}, 8'h2F);

      // R8 decay window
      pin_in = 6'h00;
      bus_write(1'b1, 8'h00);
      bus_write(1'b0, 8'hC0);
      bus_write(1'b0, 8'h00);            // release edge W
      bus_read(1'b1, r); check("R8 first read low", r, 8'h00);   // W+1
      idle(D - 2);
      bus_read(1'b1, r); check("R8 last low read", r, 8'h00);    // W+D
      bus_read(1'b1, r); check("R8 decayed high", r, 8'hC0);     // W+D+1

      // R9 release while high
      bus_write(1'b1, 8'hC0);
      bus_write(1'b0, 8'hC0);
      bus_write(1'b0, 8'h00);
      bus_read(1'b1, r); check("R9 released high", r, 8'hC0);

      // R10 cancel running window
      bus_write(1'b1, 8'h00);
      bus_write(1'b0, 8'hC0);
      bus_write(1'b0, 8'h00);
      idle(3);
      bus_write(1'b0, 8'hC0);
      bus_write(1'b1, 8'hC0);
      bus_write(1'b0, 8'h00);
      bus_read(1'b1, r); check("R10 cancelled", r, 8'hC0);

      // R11 read alongside write returns old
      bus_addr = 1'b0; bus_wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R11 old contents", rd_data, 8'h00);
      idle(2);
      check("R11 hold", rd_data, 8'h00);
      bus_read(1'b0, r); check("R11 new contents", r, 8'h3C);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule